// File: doc/BRIEF.md
# Floating-Point Control and Status Register File

This block keeps the floating-point control state of a small RISC-V style core: five sticky exception flags and a three-bit rounding mode. Software reaches this state through a single CSR access port. The port carries a request strobe, an address, an operation code and write data. It returns read data and an illegal-instruction flag.

Three addresses give three views of the same storage. The first view holds the flags alone and the second holds the rounding mode alone. The third is the combined word, with the rounding mode sitting directly above the flags. The floating-point datapath has its own strobe and flag vector, which it uses to OR newly raised exceptions into the stored flags.

Round-to-nearest-even is the only rounding mode the block accepts. Any access that would leave a different mode in the field is rejected and flagged as an illegal instruction. A rejected access changes nothing.

Top module: `fp_csr_file`

## Requirements
- R1: After reset the flags and the rounding mode are all zero. `fflags_o` reads 0 and `frm_o` reads 0.
- R2: A read at address 0x001 returns the flags in bits [4:0] and zero in every higher bit. The flag positions are invalid in bit 4, divide-by-zero in bit 3, overflow in bit 2, underflow in bit 1 and inexact in bit 0.
- R3: A read at address 0x002 returns the rounding mode in bits [2:0] and zero in every higher bit.
- R4: A read at address 0x003 returns the flags in bits [4:0], the rounding mode in bits [7:5] and zero in bits [31:8].
- R5: The operation codes are 0 for write, 1 for set, 2 for clear and 3 for read only. A write stores `csr_wdata_i` into the addressed view. A set stores the current value ORed with the data. A clear stores the current value ANDed with the inverted data. A read-only access stores nothing. Read data always shows the value held before the access, and the new value is visible from the next cycle.
- R6: An access to 0x002 or 0x003 whose resulting rounding-mode value is not 000 raises `csr_illegal_o` in the same cycle. The rounding mode does not change, and neither do the flags carried in a combined write.
- R7: A set or clear with all-zero data performs no write and never raises `csr_illegal_o`.
- R8: On every cycle that `fflags_valid_i` is high, `fflags_i` is ORed into the stored flags. Flags stay set until software clears them.
- R9: When a committed CSR write updates the flags in the same cycle as an accrual, the CSR value wins. A rounding-mode-only write, or a rejected write, does not block the accrual.
- R10: An access to any other address reads 0, raises no illegal flag and changes no state.
- R11: `fflags_o` and `frm_o` always show the stored flags and the stored rounding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_req_i | input | 1 | CSR access strobe |
| csr_addr_i | input | ADDR_W (12) | CSR address |
| csr_op_i | input | 2 | 0 write, 1 set, 2 clear, 3 read only |
| csr_wdata_i | input | XLEN (32) | Write data or bit mask |
| csr_rdata_o | output | XLEN (32) | Value of the addressed view before the access |
| csr_illegal_o | output | 1 | Access rejected for an illegal rounding mode |
| fflags_valid_i | input | 1 | Datapath accrual strobe |
| fflags_i | input | FLAG_W (5) | Exception flags raised by the datapath |
| fflags_o | output | FLAG_W (5) | Stored flags |
| frm_o | output | RM_W (3) | Stored rounding mode |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 32-bit data, five flags and a three-bit mode. The 12-bit address lets the bench probe neighbouring addresses, such as 0x000, 0x004 and 0x801, that differ from the decoded ones in low or high bits. Because the data word is 32 bits, the bench can place junk above the flag and mode fields and show that these bits are neither stored nor read back.

With all views this narrow, the bench can hit the legality boundary from each operation. These cases include a set that reaches a mode bit, a clear that leaves the mode at zero, and a write into bit 3 of the mode view, which lies outside the field. The bench also drives accrual collisions with each kind of CSR access.

// File: rtl/fp_csr_pkg.sv
package fp_csr_pkg;

  typedef enum logic [1:0] {
    CSR_OP_WRITE = 2'd0,
    CSR_OP_SET   = 2'd1,
    CSR_OP_CLEAR = 2'd2,
    CSR_OP_READ  = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    VIEW_NONE  = 2'd0,
    VIEW_FLAGS = 2'd1,
    VIEW_RMODE = 2'd2,
    VIEW_ALL   = 2'd3
  } csr_view_e;

endpackage

// File: rtl/fp_csr_view_decode.sv
module fp_csr_view_decode
  import fp_csr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned ADDR_FLAGS = 1,
  parameter int unsigned ADDR_RMODE = 2,
  parameter int unsigned ADDR_ALL   = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csr_view_e         view_o
);

  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(ADDR_FLAGS);
  localparam logic [ADDR_W-1:0] A_RMODE = ADDR_W'(ADDR_RMODE);
  localparam logic [ADDR_W-1:0] A_ALL   = ADDR_W'(ADDR_ALL);

  always_comb begin
    if (addr_i == A_FLAGS)      view_o = VIEW_FLAGS;
    else if (addr_i == A_RMODE) view_o = VIEW_RMODE;
    else if (addr_i == A_ALL)   view_o = VIEW_ALL;
    else                        view_o = VIEW_NONE;
  end

endmodule

// File: rtl/fp_csr_update.sv
module fp_csr_update
  import fp_csr_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned FLAG_W = 5,
  parameter int unsigned RM_W   = 3
) (
  input  logic              req_i,
  input  csr_view_e         view_i,
  input  csr_op_e           op_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [FLAG_W-1:0] flags_q_i,
  input  logic [RM_W-1:0]   rm_q_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic              wr_flags_o,
  output logic              wr_rm_o,
  output logic [FLAG_W-1:0] flags_d_o,
  output logic [RM_W-1:0]   rm_d_o,
  output logic              illegal_o
);

  localparam int unsigned   FIELD_W = FLAG_W + RM_W;
  localparam logic [RM_W-1:0] RM_RNE = '0;

  logic [XLEN-1:0] cur_w;
  logic [XLEN-1:0] new_w;
  logic            attempt;
  logic            touches_rm;
  logic            touches_flags;
  logic            commit;
  logic            unused_hi;

  always_comb begin
    unique case (view_i)
      VIEW_FLAGS: cur_w = XLEN'(flags_q_i);
      VIEW_RMODE: cur_w = XLEN'(rm_q_i);
      VIEW_ALL:   cur_w = XLEN'({rm_q_i, flags_q_i});
      default:    cur_w = '0;
    endcase
  end

  always_comb begin
    unique case (op_i)
      CSR_OP_WRITE: new_w = wdata_i;
      CSR_OP_SET:   new_w = cur_w | wdata_i;
      CSR_OP_CLEAR: new_w = cur_w & ~wdata_i;
      default:      new_w = cur_w;
    endcase
  end

  // set/clear with an empty mask is a pure read
  always_comb begin
    unique case (op_i)
      CSR_OP_WRITE:             attempt = req_i && (view_i != VIEW_NONE);
      CSR_OP_SET, CSR_OP_CLEAR: attempt = req_i && (view_i != VIEW_NONE) && (wdata_i != '0);
      default:                  attempt = 1'b0;
    endcase
  end

  assign touches_rm    = (view_i == VIEW_RMODE) || (view_i == VIEW_ALL);
  assign touches_flags = (view_i == VIEW_FLAGS) || (view_i == VIEW_ALL);

  assign flags_d_o = new_w[FLAG_W-1:0];
  assign rm_d_o    = (view_i == VIEW_RMODE) ? new_w[RM_W-1:0] : new_w[FLAG_W +: RM_W];

  assign illegal_o  = attempt && touches_rm && (rm_d_o != RM_RNE);
  assign commit     = attempt && !illegal_o;
  assign wr_flags_o = commit && touches_flags;
  assign wr_rm_o    = commit && touches_rm;
  assign rdata_o    = cur_w;

  assign unused_hi = ^new_w[XLEN-1:FIELD_W];

endmodule

// File: rtl/fp_csr_flag_bank.sv
module fp_csr_flag_bank #(
  parameter int unsigned FLAG_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wdata_i,
  input  logic              acc_valid_i,
  input  logic [FLAG_W-1:0] acc_i,
  output logic [FLAG_W-1:0] flags_o
);

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    logic bit_q;
    // software write outranks datapath accrual
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     bit_q <= 1'b0;
      else if (wr_i)                   bit_q <= wdata_i[b];
      else if (acc_valid_i && acc_i[b]) bit_q <= 1'b1;
    end
    assign flags_o[b] = bit_q;
  end

endmodule

// File: rtl/fp_csr_file.sv
module fp_csr_file
  import fp_csr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned FLAG_W     = 5,
  parameter int unsigned RM_W       = 3,
  parameter int unsigned ADDR_FLAGS = 1,
  parameter int unsigned ADDR_RMODE = 2,
  parameter int unsigned ADDR_ALL   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_req_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [1:0]        csr_op_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_illegal_o,
  input  logic              fflags_valid_i,
  input  logic [FLAG_W-1:0] fflags_i,
  output logic [FLAG_W-1:0] fflags_o,
  output logic [RM_W-1:0]   frm_o
);

  csr_view_e         view;
  csr_op_e           op;
  logic              wr_flags;
  logic              wr_rm;
  logic [FLAG_W-1:0] flags_d;
  logic [RM_W-1:0]   rm_d;
  logic [FLAG_W-1:0] flags_q;
  logic [RM_W-1:0]   rm_q;

  assign op = csr_op_e'(csr_op_i);

  fp_csr_view_decode #(
    .ADDR_W    (ADDR_W),
    .ADDR_FLAGS(ADDR_FLAGS),
    .ADDR_RMODE(ADDR_RMODE),
    .ADDR_ALL  (ADDR_ALL)
  ) u_decode (
    .addr_i(csr_addr_i),
    .view_o(view)
  );

  fp_csr_update #(
    .XLEN  (XLEN),
    .FLAG_W(FLAG_W),
    .RM_W  (RM_W)
  ) u_update (
    .req_i     (csr_req_i),
    .view_i    (view),
    .op_i      (op),
    .wdata_i   (csr_wdata_i),
    .flags_q_i (flags_q),
    .rm_q_i    (rm_q),
    .rdata_o   (csr_rdata_o),
    .wr_flags_o(wr_flags),
    .wr_rm_o   (wr_rm),
    .flags_d_o (flags_d),
    .rm_d_o    (rm_d),
    .illegal_o (csr_illegal_o)
  );

  fp_csr_flag_bank #(
    .FLAG_W(FLAG_W)
  ) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_flags),
    .wdata_i    (flags_d),
    .acc_valid_i(fflags_valid_i),
    .acc_i      (fflags_i),
    .flags_o    (flags_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rm_q <= '0;
    else if (wr_rm) rm_q <= rm_d;
  end

  assign fflags_o = flags_q;
  assign frm_o    = rm_q;

endmodule

// File: rtl/fp_csr_file_chk.sv
module fp_csr_file_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned FLAG_W     = 5,
  parameter int unsigned RM_W       = 3,
  parameter int unsigned ADDR_RMODE = 2,
  parameter int unsigned ADDR_ALL   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              csr_req_i,
  input logic [ADDR_W-1:0] csr_addr_i,
  input logic [1:0]        csr_op_i,
  input logic [XLEN-1:0]   csr_wdata_i,
  input logic              csr_illegal_o,
  input logic              fflags_valid_i,
  input logic [FLAG_W-1:0] fflags_i,
  input logic [FLAG_W-1:0] fflags_o,
  input logic [RM_W-1:0]   frm_o
);

  // R6
  illegal_keeps_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_illegal_o && !fflags_valid_i) |=> $stable(fflags_o));

  // R6
  rm_only_rne_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_o == '0);

  // R7
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && (csr_op_i == 2'd1 || csr_op_i == 2'd2) && csr_wdata_i == '0) |-> !csr_illegal_o);

  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_req_i |=> ((fflags_o & $past(fflags_o)) == $past(fflags_o)));

  // R8
  accrue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fflags_valid_i && !csr_req_i) |=> ((fflags_o & $past(fflags_i)) == $past(fflags_i)));

  // R10
  illegal_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> (csr_req_i && (csr_addr_i == ADDR_W'(ADDR_RMODE) || csr_addr_i == ADDR_W'(ADDR_ALL))));

endmodule

bind fp_csr_file fp_csr_file_chk #(
  .ADDR_W    (ADDR_W),
  .XLEN      (XLEN),
  .FLAG_W    (FLAG_W),
  .RM_W      (RM_W),
  .ADDR_RMODE(ADDR_RMODE),
  .ADDR_ALL  (ADDR_ALL)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_req_i     (csr_req_i),
  .csr_addr_i    (csr_addr_i),
  .csr_op_i      (csr_op_i),
  .csr_wdata_i   (csr_wdata_i),
  .csr_illegal_o (csr_illegal_o),
  .fflags_valid_i(fflags_valid_i),
  .fflags_i      (fflags_i),
  .fflags_o      (fflags_o),
  .frm_o         (frm_o)
);

// File: tb/fp_csr_file_bench.sv
module fp_csr_file_bench;

  localparam logic [1:0] OP_W = 2'd0, OP_S = 2'd1, OP_C = 2'd2, OP_R = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  op = OP_R;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        illegal;
  logic        acc_v = 1'b0;
  logic [4:0]  acc = '0;
  logic [4:0]  flags;
  logic [2:0]  rm;

  int n_vec = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_csr_file u_fp_csr_file (
    .clk_i(clk), .rst_ni(rst_n), .csr_req_i(req), .csr_addr_i(addr),
    .csr_op_i(op), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .csr_illegal_o(illegal), .fflags_valid_i(acc_v), .fflags_i(acc),
    .fflags_o(flags), .frm_o(rm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one access, optional accrual in the same cycle; rd/ill sampled before the edge
  task automatic acc_csr(input logic [11:0] a, input logic [1:0] o, input logic [31:0] wd,
                         input logic av, input logic [4:0] af,
                         output logic [31:0] rd, output logic ill);
    @(negedge clk);
    req = 1'b1; addr = a; op = o; wdata = wd; acc_v = av; acc = af;
    #1;
    rd = rdata; ill = illegal;
    @(posedge clk); #1;
    req = 1'b0; acc_v = 1'b0; acc = '0; op = OP_R; wdata = '0;
  endtask

  task automatic csr(input logic [11:0] a, input logic [1:0] o, input logic [31:0] wd,
                     output logic [31:0] rd, output logic ill);
    acc_csr(a, o, wd, 1'b0, 5'd0, rd, ill);
  endtask

  task automatic accrue(input logic v, input logic [4:0] f);
    @(negedge clk);
    acc_v = v; acc = f;
    @(posedge clk); #1;
    acc_v = 1'b0; acc = '0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic ill;
    chk("R1 flags", 32'(flags), 32'h0);
    chk("R1 rm", 32'(rm), 32'h0);
    csr(12'h003, OP_R, 32'hFFFF_FFFF, rd, ill);
    chk("R4 reset read", rd, 32'h0);
  endtask

  task automatic t_flags();
    logic [31:0] rd; logic ill;
    csr(12'h001, OP_W, 32'h0000_01F5, rd, ill);
    chk("R5 write legal", 32'(ill), 32'h0);
    chk("R11 fflags_o", 32'(flags), 32'h15);
    csr(12'h001, OP_R, 32'h0, rd, ill);
    chk("R2 flags read", rd, 32'h15);
    csr(12'h001, OP_S, 32'h0A, rd, ill);
    chk("R5 set old value", rd, 32'h15);
    chk("R5 set", 32'(flags), 32'h1F);
    csr(12'h001, OP_C, 32'h11, rd, ill);
    chk("R5 clear", 32'(flags), 32'h0E);
    csr(12'h001, OP_R, 32'hFF, rd, ill);
    chk("R5 read-only", 32'(flags), 32'h0E);
    // invalid is bit 4, inexact bit 0
    csr(12'h001, OP_W, 32'h10, rd, ill);
    csr(12'h003, OP_R, 32'h0, rd, ill);
    chk("R2 NV position", rd, 32'h10);
  endtask

  task automatic t_rmode();
    logic [31:0] rd; logic ill;
    csr(12'h002, OP_R, 32'h0, rd, ill);
    chk("R3 rm read", rd, 32'h0);
    csr(12'h002, OP_W, 32'h0, rd, ill);
    chk("R6 write RNE legal", 32'(ill), 32'h0);
    csr(12'h002, OP_W, 32'h1, rd, ill);
    chk("R6 write 001 illegal", 32'(ill), 32'h1);
    chk("R6 rm kept", 32'(rm), 32'h0);
    csr(12'h002, OP_S, 32'h4, rd, ill);
    chk("R6 set illegal", 32'(ill), 32'h1);
    csr(12'h002, OP_C, 32'h7, rd, ill);
    chk("R6 clear legal", 32'(ill), 32'h0);
    csr(12'h002, OP_W, 32'h8, rd, ill);
    chk("R3 bit3 outside field", 32'(ill), 32'h0);
    chk("R3 rm after", 32'(rm), 32'h0);
  endtask

  task automatic t_all();
    logic [31:0] rd; logic ill;
    csr(12'h003, OP_W, 32'hFFFF_FF13 & 32'h0000_001F | 32'hFF00_0000, rd, ill);
    chk("R4 upper junk legal", 32'(ill), 32'h0);
    csr(12'h003, OP_R, 32'h0, rd, ill);
    chk("R4 combined read", rd, 32'h13);
    csr(12'h003, OP_W, 32'h2F, rd, ill);
    chk("R6 combined illegal", 32'(ill), 32'h1);
    chk("R6 flags kept", 32'(flags), 32'h13);
    csr(12'h003, OP_S, 32'h80, rd, ill);
    chk("R6 combined set illegal", 32'(ill), 32'h1);
    csr(12'h003, OP_C, 32'h03, rd, ill);
    chk("R5 combined clear", 32'(flags), 32'h10);
    chk("R6 combined clear legal", 32'(ill), 32'h0);
  endtask

  task automatic t_zero_mask();
    logic [31:0] rd; logic ill;
    csr(12'h002, OP_S, 32'h0, rd, ill);
    chk("R7 set zero", 32'(ill), 32'h0);
    csr(12'h003, OP_C, 32'h0, rd, ill);
    chk("R7 clear zero trap", 32'(ill), 32'h0);
    chk("R7 clear zero flags", 32'(flags), 32'h10);
  endtask

  task automatic t_accrue();
    logic [31:0] rd; logic ill;
    csr(12'h001, OP_W, 32'h0, rd, ill);
    accrue(1'b1, 5'h01);
    chk("R8 accrue NX", 32'(flags), 32'h01);
    accrue(1'b1, 5'h10);
    chk("R8 sticky", 32'(flags), 32'h11);
    accrue(1'b0, 5'h0E);
    chk("R8 no strobe", 32'(flags), 32'h11);
    csr(12'h001, OP_R, 32'h0, rd, ill);
    chk("R8 read back", rd, 32'h11);
  endtask

  task automatic t_collide();
    logic [31:0] rd; logic ill;
    acc_csr(12'h001, OP_W, 32'h04, 1'b1, 5'h03, rd, ill);
    chk("R9 write wins", 32'(flags), 32'h04);
    acc_csr(12'h002, OP_W, 32'h0, 1'b1, 5'h08, rd, ill);
    chk("R9 rm write keeps accrual", 32'(flags), 32'h0C);
    acc_csr(12'h003, OP_W, 32'h20, 1'b1, 5'h01, rd, ill);
    chk("R9 rejected keeps accrual", 32'(flags), 32'h0D);
    chk("R9 rejected illegal", 32'(ill), 32'h1);
  endtask

  task automatic t_miss();
    logic [31:0] rd; logic ill;
    csr(12'h000, OP_W, 32'hFF, rd, ill);
    chk("R10 addr 0 read", rd, 32'h0);
    chk("R10 addr 0 trap", 32'(ill), 32'h0);
    csr(12'h004, OP_W, 32'hE0, rd, ill);
    chk("R10 addr 4 trap", 32'(ill), 32'h0);
    csr(12'h801, OP_W, 32'h0, rd, ill);
    chk("R10 addr 801 read", rd, 32'h0);
    chk("R10 flags kept", 32'(flags), 32'h0D);
    chk("R10 rm kept", 32'(rm), 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flags();
    t_rmode();
    t_all();
    t_zero_mask();
    t_accrue();
    t_collide();
    t_miss();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_err++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule